// File: doc/BRIEF.md
# Integer Add Unit with Exception and Condition Flags

This execution unit runs the 32-bit integer add family. Each accepted issue takes two register operands, a 16-bit signed immediate, an opcode and two control bits: overflow-enable and record. One clock edge later the unit presents a registered 32-bit result. On that same edge it updates an exception register with three bits. These are the carry (CA), the overflow (OV) and a sticky summary overflow (SO). When a record is requested, it also updates a 4-bit condition field.

The operation set covers several groups:
- plain and carrying adds;
- adds that consume the stored carry (extended, to minus one, to zero);
- four immediate forms, one of which shifts the immediate up by 16 bits;
- absolute value;
- difference-or-zero, with register and immediate forms.

Each operation class follows its own rule for which flags it writes. A separate write port loads the exception register directly. That port is the only way to clear SO. Register file, decode and pipelining sit outside this block.

Opcode encoding on `op_sel`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | add carrying |
| 2 | add extended |
| 3 | add to minus one |
| 4 | add to zero |
| 5 | add immediate |
| 6 | add immediate carrying |
| 7 | add immediate carrying and record |
| 8 | add immediate shifted |
| 9 | absolute value |
| 10 | difference-or-zero |
| 11 | difference-or-zero immediate |

Codes 12 to 15 return 0 and write no flag.

The register forms are codes 0 to 4, 9 and 10.

Top module: `int_addflag_unit`

## Requirements
- R1: After reset the outputs hold these values: `res_out` = 0, `res_valid` = 0, CA = OV = SO = 0 and `cond_fld` = 0.
- R2: Add (code 0) places A+B modulo 2^32 in `res_out` on the edge after issue. It leaves CA unchanged.
- R3: Add carrying (code 1), add immediate carrying (code 6) and its record form (code 7) each write the carry-out of their sum to CA.
- R4: The stored-carry adds each use the CA value held before the issue, and each writes its own carry-out back to CA:
  - add extended (code 2) gives A+B+CA;
  - add to minus one (code 3) gives A+CA+0xFFFFFFFF;
  - add to zero (code 4) gives A+CA.
- R5: The immediate adds (codes 5 to 8) use the sign-extended immediate. Code 8 shifts that immediate left by 16. When `a_sel_zero` is 1, these codes use 0 in place of A. Codes 5 and 8 leave CA unchanged.
- R6: With `ovf_en` = 1, a register form writes OV with its signed overflow. With `ovf_en` = 0 OV is unchanged. The immediate forms never write OV.
- R7: SO is set whenever OV is written as 1. No operation clears SO.
- R8: The condition field is `cond_fld` = {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0.
  - It is written by a register form with `rec_en` = 1, and always by code 7. It is otherwise unchanged.
  - LT, GT and EQ compare the result with zero as a signed number.
  - The SO bit copies SO after the same update.
- R9: Absolute value (code 9) gives |A|. For A = 0x80000000 it gives 0x80000000 and, with `ovf_en` set, sets OV. CA is unchanged.
- R10: Difference-or-zero (code 10) gives 0 when A > B as signed numbers, and B−A (NOT A + B + 1) otherwise. Code 11 uses the sign-extended immediate in place of B. With `ovf_en` set, OV takes the signed overflow of B−A, or 0 when the result is forced to 0. CA is unchanged.
- R11: `xer_wr_en` loads SO, OV and CA from `xer_wr_data` bits 2, 1 and 0. An issue in the same cycle is dropped: `res_valid` stays 0, and both `res_out` and `cond_fld` are unchanged.
- R12: `res_valid` is 1 for exactly the cycle after each accepted issue and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Start an operation this cycle |
| op_sel | input | 4 | Opcode (see table) |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| a_sel_zero | input | 1 | A field names register 0 (immediate adds use 0) |
| imm | input | 16 | Signed immediate |
| ovf_en | input | 1 | Overflow-enable for register forms |
| rec_en | input | 1 | Record: update the condition field |
| xer_wr_en | input | 1 | Direct exception-register load |
| xer_wr_data | input | 3 | {SO, OV, CA} load value |
| res_out | output | 32 | Registered result |
| res_valid | output | 1 | Result produced this cycle |
| ca_flag | output | 1 | Carry bit |
| ov_flag | output | 1 | Overflow bit |
| so_flag | output | 1 | Sticky summary overflow bit |
| cond_fld | output | 4 | {LT, GT, EQ, SO} |

## Verification
Codes 0 and 1 run over every pair drawn from 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, with overflow-enable and record toggled. These pairs separate:
- unsigned carry from signed overflow;
- a negative result from a positive or zero one.

The stored-carry adds run with CA forced to 0 and to 1. This shows that the old carry is consumed and the new one written back. Immediate tests cover both sign extremes of the immediate, the shifted form and the register-0 substitution. Absolute value and difference-or-zero are tried on:
- the most negative operand;
- equal operands;
- A above B and A below B.

A final pair of tests shows that SO survives a later non-overflowing operation, and that a direct load wins over an issue in the same cycle.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned CR_W   = 4;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_ADD         = 4'd0,
    OP_ADD_CY      = 4'd1,
    OP_ADD_EXT     = 4'd2,
    OP_ADD_M1      = 4'd3,
    OP_ADD_Z       = 4'd4,
    OP_ADD_IMM     = 4'd5,
    OP_ADD_IMM_CY  = 4'd6,
    OP_ADD_IMM_CYR = 4'd7,
    OP_ADD_IMM_HI  = 4'd8,
    OP_ABS         = 4'd9,
    OP_DIFZ        = 4'd10,
    OP_DIFZ_IMM    = 4'd11,
    OP_RSV12       = 4'd12,
    OP_RSV13       = 4'd13,
    OP_RSV14       = 4'd14,
    OP_RSV15       = 4'd15
  } op_e;

  typedef struct packed {
    logic  cout;
    word_t sum;
  } sum_t;

  // Full add with carry-in; the extra top bit carries out.
  function automatic sum_t add_cin(word_t a, word_t b, logic cin);
    logic [DATA_W:0] t;
    t = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    return sum_t'(t);
  endfunction

  // Signed overflow of a + b (+cin): equal operand signs, differing sum sign.
  function automatic logic add_ovf(word_t a, word_t b, word_t s);
    return (a[DATA_W-1] == b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
  endfunction

  function automatic word_t sext_imm(logic [IMM_W-1:0] i);
    return word_t'({{(DATA_W-IMM_W){i[IMM_W-1]}}, i});
  endfunction

  function automatic word_t shift_imm(logic [IMM_W-1:0] i);
    return word_t'({i, {(DATA_W-IMM_W){1'b0}}});
  endfunction

  // {LT, GT, EQ, SO} from a signed compare of r with zero.
  function automatic logic [CR_W-1:0] cr_of(word_t r, logic so);
    logic zero;
    zero = (r == '0);
    return {r[DATA_W-1], !r[DATA_W-1] && !zero, zero, so};
  endfunction

  function automatic logic is_reg_form(op_e op);
    return op inside {OP_ADD, OP_ADD_CY, OP_ADD_EXT, OP_ADD_M1, OP_ADD_Z,
                      OP_ABS, OP_DIFZ};
  endfunction

  function automatic logic writes_ca(op_e op);
    return op inside {OP_ADD_CY, OP_ADD_EXT, OP_ADD_M1, OP_ADD_Z,
                      OP_ADD_IMM_CY, OP_ADD_IMM_CYR};
  endfunction

  function automatic logic is_imm_add(op_e op);
    return op inside {OP_ADD_IMM, OP_ADD_IMM_CY, OP_ADD_IMM_CYR, OP_ADD_IMM_HI};
  endfunction
endpackage

// File: rtl/iau_opnd_sel.sv
module iau_opnd_sel
  import iau_pkg::*;
(
  input  op_e              op,
  input  word_t            src_a,
  input  word_t            src_b,
  input  logic             a_zero,
  input  logic [IMM_W-1:0] imm,
  input  logic             ca_cur,
  input  logic             ovf_en,
  input  logic             rec_en,
  output word_t            a_eff,
  output word_t            y_eff,
  output logic             cin,
  output logic             ca_we,
  output logic             ov_we,
  output logic             cr_we
);
  always_comb begin
    a_eff = (is_imm_add(op) && a_zero) ? '0 : src_a;
    y_eff = '0;
    cin   = 1'b0;
    unique case (op)
      OP_ADD, OP_ADD_CY:                        y_eff = src_b;
      OP_ADD_EXT:    begin y_eff = src_b;       cin = ca_cur; end
      OP_ADD_M1:     begin y_eff = '1;          cin = ca_cur; end
      OP_ADD_Z:      begin y_eff = '0;          cin = ca_cur; end
      OP_ADD_IMM, OP_ADD_IMM_CY, OP_ADD_IMM_CYR: y_eff = sext_imm(imm);
      OP_ADD_IMM_HI:                            y_eff = shift_imm(imm);
      OP_DIFZ:                                  y_eff = src_b;
      OP_DIFZ_IMM:                              y_eff = sext_imm(imm);
      default:                                  y_eff = '0;
    endcase
  end

  assign ca_we = writes_ca(op);
  assign ov_we = ovf_en && is_reg_form(op);
  assign cr_we = (rec_en && is_reg_form(op)) || (op == OP_ADD_IMM_CYR);
endmodule

// File: rtl/iau_arith.sv
module iau_arith
  import iau_pkg::*;
(
  input  op_e   op,
  input  word_t a_eff,
  input  word_t y_eff,
  input  logic  cin,
  output word_t res,
  output logic  cout,
  output logic  ovf
);
  localparam word_t MOST_NEG = word_t'(1) << (DATA_W-1);

  sum_t  sum_c;
  word_t neg_a;
  word_t diff;
  logic  a_gt_y;
  logic  diff_ovf;

  assign sum_c    = add_cin(a_eff, y_eff, cin);
  assign neg_a    = ~a_eff + word_t'(1);
  assign diff     = ~a_eff + y_eff + word_t'(1);
  assign a_gt_y   = $signed(a_eff) > $signed(y_eff);
  // y - a overflows when signs differ and the difference leaves y's sign.
  assign diff_ovf = (a_eff[DATA_W-1] != y_eff[DATA_W-1]) &&
                    (diff[DATA_W-1] != y_eff[DATA_W-1]);

  always_comb begin
    res  = '0;
    cout = 1'b0;
    ovf  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADD_CY, OP_ADD_EXT, OP_ADD_M1, OP_ADD_Z,
      OP_ADD_IMM, OP_ADD_IMM_CY, OP_ADD_IMM_CYR, OP_ADD_IMM_HI: begin
        res  = sum_c.sum;
        cout = sum_c.cout;
        ovf  = add_ovf(a_eff, y_eff, sum_c.sum);
      end
      OP_ABS: begin
        res = a_eff[DATA_W-1] ? neg_a : a_eff;
        ovf = (a_eff == MOST_NEG);
      end
      OP_DIFZ, OP_DIFZ_IMM: begin
        res = a_gt_y ? '0 : diff;
        ovf = a_gt_y ? 1'b0 : diff_ovf;
      end
      default: begin
        res  = '0;
        cout = 1'b0;
        ovf  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/iau_flags.sv
module iau_flags
  import iau_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            xer_wr_en,
  input  logic [2:0]      xer_wr_data,
  input  logic            ca_we,
  input  logic            ca_new,
  input  logic            ov_we,
  input  logic            ov_new,
  input  logic            cr_we,
  input  word_t           res_new,
  output logic            ca_q,
  output logic            ov_q,
  output logic            so_q,
  output logic [CR_W-1:0] cr_q
);
  logic so_next;
  assign so_next = so_q | (ov_we & ov_new);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_q <= 1'b0;
      ov_q <= 1'b0;
      so_q <= 1'b0;
      cr_q <= '0;
    end else if (xer_wr_en) begin
      so_q <= xer_wr_data[2];
      ov_q <= xer_wr_data[1];
      ca_q <= xer_wr_data[0];
    end else if (fire) begin
      if (ca_we) ca_q <= ca_new;
      if (ov_we) ov_q <= ov_new;
      so_q <= so_next;
      if (cr_we) cr_q <= cr_of(res_new, so_next);
    end
  end

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (so_q && !xer_wr_en) |=> so_q); // R7
  AST_OV_SETS_SO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ov_we && ov_new) |=> (so_q && ov_q)); // R7
  AST_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ca_we) |=> $stable(ca_q)); // R2
  AST_CR_ONE_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cr_we) |=> ($countones(cr_q[CR_W-1:1]) == 1)); // R8
  AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cr_we) |=> (cr_q[0] == so_q)); // R8
  AST_XER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xer_wr_en |=> ({so_q, ov_q, ca_q} == $past(xer_wr_data))); // R11
endmodule

// File: rtl/int_addflag_unit.sv
module int_addflag_unit
  import iau_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_valid,
  input  logic [3:0]             op_sel,
  input  logic [DATA_W-1:0]      opnd_a,
  input  logic [DATA_W-1:0]      opnd_b,
  input  logic                   a_sel_zero,
  input  logic [IMM_W-1:0]       imm,
  input  logic                   ovf_en,
  input  logic                   rec_en,
  input  logic                   xer_wr_en,
  input  logic [2:0]             xer_wr_data,
  output logic [DATA_W-1:0]      res_out,
  output logic                   res_valid,
  output logic                   ca_flag,
  output logic                   ov_flag,
  output logic                   so_flag,
  output logic [CR_W-1:0]        cond_fld
);
  localparam word_t MOST_NEG = word_t'(1) << (DATA_W-1);

  op_e   op_c;
  word_t a_eff, y_eff, res_c;
  logic  cin, ca_we, ov_we, cr_we, cout_c, ovf_c;
  logic  fire;

  assign op_c = op_e'(op_sel);
  assign fire = issue_valid && !xer_wr_en;

  iau_opnd_sel u_sel (
    .op     (op_c),
    .src_a  (opnd_a),
    .src_b  (opnd_b),
    .a_zero (a_sel_zero),
    .imm    (imm),
    .ca_cur (ca_flag),
    .ovf_en (ovf_en),
    .rec_en (rec_en),
    .a_eff  (a_eff),
    .y_eff  (y_eff),
    .cin    (cin),
    .ca_we  (ca_we),
    .ov_we  (ov_we),
    .cr_we  (cr_we)
  );

  iau_arith u_arith (
    .op    (op_c),
    .a_eff (a_eff),
    .y_eff (y_eff),
    .cin   (cin),
    .res   (res_c),
    .cout  (cout_c),
    .ovf   (ovf_c)
  );

  iau_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .xer_wr_en   (xer_wr_en),
    .xer_wr_data (xer_wr_data),
    .ca_we       (ca_we),
    .ca_new      (cout_c),
    .ov_we       (ov_we),
    .ov_new      (ovf_c),
    .cr_we       (cr_we),
    .res_new     (res_c),
    .ca_q        (ca_flag),
    .ov_q        (ov_flag),
    .so_q        (so_flag),
    .cr_q        (cond_fld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) res_out <= res_c;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !xer_wr_en) |=> res_valid); // R12
  AST_DROP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xer_wr_en |=> (!res_valid && $stable(res_out))); // R11
  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_c == OP_ABS && opnd_a != MOST_NEG) |=> !res_out[DATA_W-1]); // R9
  AST_DIFZ_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_c == OP_DIFZ && $signed(opnd_a) > $signed(opnd_b))
      |=> (res_out == '0)); // R10
endmodule

// File: tb/test_int_addflag_unit.sv
module test_int_addflag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        a_sel_zero = 1'b0;
  logic [15:0] imm = '0;
  logic        ovf_en = 1'b0, rec_en = 1'b0;
  logic        xer_wr_en = 1'b0;
  logic [2:0]  xer_wr_data = '0;
  logic [31:0] res_out;
  logic        res_valid, ca_flag, ov_flag, so_flag;
  logic [3:0]  cond_fld;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Expected state, kept by the bench
  logic [31:0] e_res = '0;
  logic        e_ca = 0, e_ov = 0, e_so = 0;
  logic [3:0]  e_cr = '0;

  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
  logic [15:0] imms    [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  int_addflag_unit i_int_addflag_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .a_sel_zero(a_sel_zero), .imm(imm),
    .ovf_en(ovf_en), .rec_en(rec_en), .xer_wr_en(xer_wr_en),
    .xer_wr_data(xer_wr_data), .res_out(res_out), .res_valid(res_valid),
    .ca_flag(ca_flag), .ov_flag(ov_flag), .so_flag(so_flag), .cond_fld(cond_fld)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "result", res_out, e_res);
    chk(req, "CA", {31'b0, ca_flag}, {31'b0, e_ca});
    chk(req, "OV", {31'b0, ov_flag}, {31'b0, e_ov});
    chk(req, "SO", {31'b0, so_flag}, {31'b0, e_so});
    chk(req, "cond", {28'b0, cond_fld}, {28'b0, e_cr});
  endtask

  // Reference model, in 64-bit signed/unsigned arithmetic.
  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input bit r0, input bit oe, input bit rc);
    longint sa, sb, sx, s, u, ua, ub;
    logic [31:0] ae;
    bit regf, wca, wov, wcr, c, v;
    ae = ((op >= 5 && op <= 8) && r0) ? 32'h0 : a;
    sa = longint'($signed(ae));
    sb = longint'($signed(b));
    sx = longint'($signed(im));
    ua = longint'({32'h0, ae});
    ub = longint'({32'h0, b});
    u  = 0;
    case (op)
      0, 1: begin u = ua + ub; s = sa + sb; end
      2: begin u = ua + ub + longint'(e_ca); s = sa + sb + longint'(e_ca); end
      3: begin u = ua + 64'hFFFFFFFF + longint'(e_ca); s = sa - 1 + longint'(e_ca); end
      4: begin u = ua + longint'(e_ca); s = sa + longint'(e_ca); end
      5, 6, 7: begin u = ua + (sx & 64'hFFFFFFFF); s = sa + sx; end
      8: s = sa + sx * 65536;
      9: s = (sa < 0) ? -sa : sa;
      10: s = (sa > sb) ? 0 : sb - sa;
      11: s = (sa > sx) ? 0 : sx - sa;
      default: s = 0;
    endcase
    c = u[32];
    v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    regf = (op <= 4) || op == 9 || op == 10;
    wca = (op >= 1 && op <= 4) || op == 6 || op == 7;
    wov = oe && regf;
    wcr = (rc && regf) || op == 7;
    e_res = s[31:0];
    if (wca) e_ca = c;
    if (wov) begin e_ov = v; e_so = e_so | v; end
    if (wcr) e_cr = {e_res[31], !e_res[31] && e_res != 0, e_res == 0, e_so};
  endtask

  task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input bit r0, input bit oe, input bit rc);
    op_sel = op[3:0]; opnd_a = a; opnd_b = b; imm = im;
    a_sel_zero = r0; ovf_en = oe; rec_en = rc; issue_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    model(op, a, b, im, r0, oe, rc);
  endtask

  task automatic xer_load(input logic [2:0] d);
    xer_wr_en = 1'b1; xer_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    xer_wr_en = 1'b0;
    {e_so, e_ov, e_ca} = d;
  endtask

  task automatic t_reset;
    chk("R1", "result", res_out, 32'h0);
    chk("R1", "valid", {31'b0, res_valid}, 32'h0);
    chk("R1", "xer", {29'b0, so_flag, ov_flag, ca_flag}, 32'h0);
    chk("R1", "cond", {28'b0, cond_fld}, 32'h0);
  endtask

  // R2 R3 R6 R8: add and add carrying over all corner pairs
  task automatic t_add_corners;
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          issue(op, corners[i], corners[j], 16'h0, 1'b0, bit'(j % 2), bit'(i % 2));
          chk_all(op == 0 ? "R2/R6/R8" : "R3/R6/R8");
        end
  endtask

  // R4: stored-carry adds with CA forced each way
  task automatic t_carry_chain;
    for (int op = 2; op < 5; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int i = 0; i < 5; i++) begin
          xer_load({2'b00, ci[0]});
          issue(op, corners[i], corners[4 - i], 16'h0, 1'b0, 1'b1, 1'b1);
          chk_all("R4");
        end
  endtask

  // R5: immediate forms, with oe/rc set to show they are ignored (except code 7 CR)
  task automatic t_imm;
    for (int op = 5; op < 9; op++)
      for (int i = 0; i < 5; i++) begin
        xer_load(3'b001);
        issue(op, corners[i], 32'h0, imms[i], 1'b0, 1'b1, 1'b1);
        chk_all("R5");
        issue(op, corners[i], 32'h0, imms[4 - i], 1'b1, 1'b1, 1'b0);
        chk_all("R5");
      end
  endtask

  // R9: absolute value
  task automatic t_abs;
    xer_load(3'b001);
    for (int i = 0; i < 5; i++) begin
      issue(9, corners[i], 32'h0, 16'h0, 1'b0, 1'b1, 1'b1);
      chk_all("R9");
    end
    issue(9, 32'hFFFFFF85, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R9", "abs(-123)", res_out, 32'd123);
  endtask

  // R10: difference-or-zero, register and immediate
  task automatic t_difz;
    xer_load(3'b000);
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        issue(10, corners[i], corners[j], 16'h0, 1'b0, 1'b1, 1'b1);
        chk_all("R10");
      end
    issue(10, 32'd5, 32'd5, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R10", "equal operands", res_out, 32'h0);
    issue(10, 32'd9, 32'd4, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R10", "A above B", res_out, 32'h0);
    for (int i = 0; i < 5; i++) begin
      issue(11, corners[i], 32'h0, imms[i], 1'b0, 1'b0, 1'b0);
      chk_all("R10");
    end
  endtask

  // R7: SO stays set after a non-overflowing OV write
  task automatic t_sticky;
    xer_load(3'b000);
    issue(0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 1'b1, 1'b0);
    chk("R7", "SO after ovf", {31'b0, so_flag}, 32'h1);
    issue(0, 32'h1, 32'h1, 16'h0, 1'b0, 1'b1, 1'b1);
    chk("R7", "OV cleared", {31'b0, ov_flag}, 32'h0);
    chk("R7", "SO held", {31'b0, so_flag}, 32'h1);
    chk("R8", "cond SO copy", {28'b0, cond_fld}, 32'h5);
  endtask

  // R11: direct load, and collision with an issue
  task automatic t_xer_load;
    xer_load(3'b101);
    chk_all("R11");
    issue(0, 32'h10, 32'h20, 16'h0, 1'b0, 1'b0, 1'b1);
    opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1; op_sel = 4'd1;
    ovf_en = 1'b1; rec_en = 1'b1; issue_valid = 1'b1;
    xer_wr_en = 1'b1; xer_wr_data = 3'b010;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0; xer_wr_en = 1'b0;
    {e_so, e_ov, e_ca} = 3'b010;
    chk("R11", "valid on collision", {31'b0, res_valid}, 32'h0);
    chk_all("R11");
  endtask

  // R12: one-cycle valid pulse
  task automatic t_valid;
    issue(0, 32'h3, 32'h4, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R12", "valid after issue", {31'b0, res_valid}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    chk("R12", "valid idle", {31'b0, res_valid}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add_corners();
    t_carry_chain();
    t_imm();
    t_abs();
    t_difz();
    t_sticky();
    t_xer_load();
    t_valid();
    finish_run();
  end
endmodule